// File: doc/BRIEF.md
# RC Oscillator Resistance-to-Count Converter

This block turns a resistance into a number by racing two 16-bit up-counters. A reference counter advances on the system clock, while a measurement counter advances on the rising edges of an external RC oscillator, whose frequency depends on the resistor connected to it. Software loads start values, sets the run bit, and waits for the interrupt flag. The flag is raised when the counter chosen as the time base rolls over. Both counters then freeze, and the ratio of their counts gives the resistance.

Software reaches the block over a byte-wide register bus. Each 16-bit counter is read and written through its own low-byte staging buffer, so that a value which is still changing is never torn between two bytes. A mode bit drives a sense-select output, which picks either the reference resistor or the sensor resistor for the external oscillator. The oscillator output enters the block as a plain digital signal. It is synchronized to the system clock inside the block.

Top module: `rcadc_timer`

## Requirements
- R1: After reset, every register reads 0, and both `irq_flag` and `sense_sel` are 0.
- R2: A bus write to a low-byte address (A_LO=2, B_LO=4) changes only that counter's staging buffer. A write to the matching high-byte address (A_HI=3, B_HI=5) loads {written byte, staged byte} into the 16-bit counter in that one cycle.
- R3: A read of a high-byte address returns the counter's upper byte, and in the same access it copies the counter's lower byte into that counter's buffer. A read of a low-byte address returns the buffer and never the live counter. Counter A and counter B each keep a separate buffer.
- R4: Counter A advances by one on every clock while the run bit (CTRL=0, bit 4) is 1, ADC mode is on, and the source field (CTRL bits 1:0) equals 2'b10. With any other source value, counter A holds.
- R5: Counter B advances by one for each rising edge of `rc_osc`, after a two-flop synchronizer, while the run bit is 1 and ADC mode is on.
- R6: The overflow-select bit (MODE=1, bit 0; 0 selects A, 1 selects B) picks the end counter. When the selected counter wraps from 16'hFFFF to 0, the run bit clears and the flag (CTRL bit 5) sets, both on that edge. A wrap of the counter that was not selected lets the run continue.
- R7: While the run bit is 1, writes to the four data addresses are ignored and reads from them return 0.
- R8: Once set, the flag stays at 1 until a CTRL write with bit 5 equal to 0, or an `irq_clr` pulse. A CTRL write with bit 5 equal to 1 leaves the flag as it is.
- R9: `sense_sel` equals MODE bit 2.
- R10: While ADC mode (MODE bit 1) is 0, neither counter advances, even with the run bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rc_osc | input | 1 | Digital output of the external RC oscillator |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Interrupt flag, set on the end-of-conversion overflow |
| sense_sel | output | 1 | Selects the reference (0) or sensor (1) resistor |

## Verification
The buffered access path is driven with random 16-bit values on both counters in random order. Extra low-byte writes to the other counter, or to the same counter after its high byte, are mixed in. This separates a design that keeps two buffers from one that shares a buffer, and it separates a reload on a high-byte read from a buffer that keeps stale data. Directed runs place counter A or counter B just below rollover and check the exact cycle on which the flag rises. They also check that the counter not selected wraps without ending the run. Runs with a wrong clock source, with ADC mode off, and with bus traffic while running check that the counters keep their values.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_MODE = 3'd1,
        ADDR_A_LO = 3'd2,
        ADDR_A_HI = 3'd3,
        ADDR_B_LO = 3'd4,
        ADDR_B_HI = 3'd5
    } reg_addr_e;

    localparam int CTRL_RUN_BIT  = 4;
    localparam int CTRL_FLAG_BIT = 5;
    localparam logic [1:0] SRC_SYSCLK = 2'b10;

    localparam int MODE_OVF_BIT   = 0;
    localparam int MODE_ADC_BIT   = 1;
    localparam int MODE_SENSE_BIT = 2;

    typedef struct packed {
        logic       run;
        logic       flag;
        logic [1:0] src;
        logic       ovf_b;
        logic       adc_en;
        logic       sense;
    } ctrl_state_t;
endpackage

// File: rtl/rcadc_edge_sync.sv
module rcadc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain = {state_q.chain[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rise_o = state_q.chain[CHAIN_W-2] & ~state_q.chain[CHAIN_W-1];

    // R5
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rcadc_counter.sv
module rcadc_counter #(
    parameter int WIDTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              rd_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [WIDTH-1:0]  cnt_o,
    output logic [BYTE_W-1:0] lobuf_o,
    output logic              wrap_o
);
    localparam int HI_W = WIDTH - BYTE_W;

    typedef struct packed {
        logic [WIDTH-1:0]  cnt;
        logic [BYTE_W-1:0] lobuf;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_hi_i) begin
            state_d.cnt = {wdata_i[HI_W-1:0], state_q.lobuf};
        end else if (inc_i) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        if (wr_lo_i) begin
            state_d.lobuf = wdata_i;
        end else if (rd_hi_i) begin
            state_d.lobuf = state_q.cnt[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt_o   = state_q.cnt;
    assign lobuf_o = state_q.lobuf;
    assign wrap_o  = inc_i & (&state_q.cnt);

    // R2
    lo_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i && !inc_i) |=> (cnt_o == $past(cnt_o)));

    // R3
    hi_read_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_i && !wr_lo_i) |=> (lobuf_o == $past(cnt_o[BYTE_W-1:0])));
endmodule

// File: rtl/rcadc_timer.sv
module rcadc_timer
    import rcadc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [2:0]          bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                rc_osc,
    input  logic                irq_clr,
    output logic                irq_flag,
    output logic                sense_sel
);
    localparam int HI_SHIFT = CNT_W - BYTE_W;

    ctrl_state_t state_d, state_q;

    logic             osc_rise;
    logic             wr_acc, rd_acc, data_open;
    logic             inc_a, inc_b, wrap_a, wrap_b, stop_now;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    logic [BYTE_W-1:0] buf_a, buf_b;

    assign wr_acc    = bus_sel & bus_we;
    assign rd_acc    = bus_sel & ~bus_we;
    assign data_open = ~state_q.run;

    assign inc_a = state_q.run & state_q.adc_en & (state_q.src == SRC_SYSCLK);
    assign inc_b = state_q.run & state_q.adc_en & osc_rise;

    rcadc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rc_osc),
        .rise_o  (osc_rise)
    );

    rcadc_counter #(.WIDTH(CNT_W), .BYTE_W(BYTE_W)) u_cnt_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc_a),
        .wr_lo_i (wr_acc & data_open & (bus_addr == ADDR_A_LO)),
        .wr_hi_i (wr_acc & data_open & (bus_addr == ADDR_A_HI)),
        .rd_hi_i (rd_acc & data_open & (bus_addr == ADDR_A_HI)),
        .wdata_i (bus_wdata),
        .cnt_o   (cnt_a),
        .lobuf_o (buf_a),
        .wrap_o  (wrap_a)
    );

    rcadc_counter #(.WIDTH(CNT_W), .BYTE_W(BYTE_W)) u_cnt_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc_b),
        .wr_lo_i (wr_acc & data_open & (bus_addr == ADDR_B_LO)),
        .wr_hi_i (wr_acc & data_open & (bus_addr == ADDR_B_HI)),
        .rd_hi_i (rd_acc & data_open & (bus_addr == ADDR_B_HI)),
        .wdata_i (bus_wdata),
        .cnt_o   (cnt_b),
        .lobuf_o (buf_b),
        .wrap_o  (wrap_b)
    );

    assign stop_now = state_q.ovf_b ? wrap_b : wrap_a;

    always_comb begin
        state_d = state_q;
        if (wr_acc && bus_addr == ADDR_CTRL) begin
            state_d.run = bus_wdata[CTRL_RUN_BIT];
            state_d.src = bus_wdata[1:0];
            if (!bus_wdata[CTRL_FLAG_BIT]) state_d.flag = 1'b0;
        end
        if (wr_acc && bus_addr == ADDR_MODE) begin
            state_d.ovf_b  = bus_wdata[MODE_OVF_BIT];
            state_d.adc_en = bus_wdata[MODE_ADC_BIT];
            state_d.sense  = bus_wdata[MODE_SENSE_BIT];
        end
        if (irq_clr) state_d.flag = 1'b0;
        if (stop_now) begin
            state_d.run  = 1'b0;
            state_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]  = state_q.run;
                bus_rdata[CTRL_FLAG_BIT] = state_q.flag;
                bus_rdata[1:0]           = state_q.src;
            end
            ADDR_MODE: begin
                bus_rdata[MODE_OVF_BIT]   = state_q.ovf_b;
                bus_rdata[MODE_ADC_BIT]   = state_q.adc_en;
                bus_rdata[MODE_SENSE_BIT] = state_q.sense;
            end
            ADDR_A_LO: if (data_open) bus_rdata = buf_a;
            ADDR_A_HI: if (data_open) bus_rdata = cnt_a[HI_SHIFT +: BYTE_W];
            ADDR_B_LO: if (data_open) bus_rdata = buf_b;
            ADDR_B_HI: if (data_open) bus_rdata = cnt_b[HI_SHIFT +: BYTE_W];
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_flag  = state_q.flag;
    assign sense_sel = state_q.sense;

    // R6
    stop_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.ovf_b ? wrap_b : wrap_a)) |=> (!state_q.run && irq_flag));

    // R6
    unselected_wrap_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_a && state_q.ovf_b && !wrap_b && !wr_acc) |=> state_q.run);

    // R7
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && rd_acc && bus_addr >= ADDR_A_LO) |-> (bus_rdata == '0));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr &&
         !(wr_acc && bus_addr == ADDR_CTRL && !bus_wdata[CTRL_FLAG_BIT])) |=> irq_flag);

    // R10
    idle_when_adc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.adc_en && !wr_acc) |=> (cnt_a == $past(cnt_a) && cnt_b == $past(cnt_b)));
endmodule

// File: tb/rcadc_timer_tb.sv
module rcadc_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rc_osc = 1'b0, irq_clr = 1'b0;
    logic       irq_flag, sense_sel;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcadc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rc_osc(rc_osc), .irq_clr(irq_clr), .irq_flag(irq_flag), .sense_sel(sense_sel)
    );

    function automatic logic [7:0] ctrl_byte(bit run, bit flag, logic [1:0] src);
        return {2'b00, flag, run, 2'b00, src};
    endfunction

    function automatic logic [7:0] mode_byte(bit sense, bit adc, bit ovf_b);
        return {5'b0, sense, adc, ovf_b};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic load16(input bit is_b, input logic [15:0] v);
        wr(is_b ? 3'd4 : 3'd2, v[7:0]);
        wr(is_b ? 3'd5 : 3'd3, v[15:8]);
    endtask

    task automatic read16(input bit is_b, output logic [15:0] v);
        logic [7:0] h, l;
        rd(is_b ? 3'd5 : 3'd3, h);
        rd(is_b ? 3'd4 : 3'd2, l);
        v = {h, l};
    endtask

    task automatic osc_pulse();
        rc_osc = 1; repeat (4) @(negedge clk);
        rc_osc = 0; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, va, vb;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            check(b == 8'h00, "R1 reset reg", b, 0);
        end
        check(irq_flag == 0 && sense_sel == 0, "R1 reset outputs", {irq_flag, sense_sel}, 0);

        // R2: low write alone leaves counter unchanged
        load16(0, 16'h1234);
        wr(3'd2, 8'hEE);
        rd(3'd3, b);
        rd(3'd2, b);
        check(b == 8'h34, "R2 lo write buffered only", b, 8'h34);

        // R2/R3 random buffered access, interleaved counters
        va = 16'h1234; vb = 16'h0000;
        for (int i = 0; i < 40; i++) begin
            bit which = 1'($urandom_range(0, 1));
            v = 16'($urandom);
            if (which) vb = v; else va = v;
            wr(which ? 3'd4 : 3'd2, v[7:0]);
            if ($urandom_range(0, 1)) wr(which ? 3'd2 : 3'd4, 8'($urandom));
            wr(which ? 3'd5 : 3'd3, v[15:8]);
            if ($urandom_range(0, 1)) wr(which ? 3'd4 : 3'd2, 8'($urandom));
            read16(which, v);
            check(v == (which ? vb : va), "R2 R3 buffered 16-bit access", v, which ? vb : va);
        end
        read16(0, v);
        check(v == va, "R3 counter A buffer independent", v, va);
        read16(1, v);
        check(v == vb, "R3 counter B buffer independent", v, vb);

        // R9 sense select
        wr(3'd1, mode_byte(1, 0, 0));
        check(sense_sel == 1, "R9 sense high", sense_sel, 1);
        wr(3'd1, mode_byte(0, 0, 0));
        check(sense_sel == 0, "R9 sense low", sense_sel, 0);

        // R10 adc off: no counting
        load16(0, 16'h4321);
        wr(3'd0, ctrl_byte(1, 0, 2'b10));
        repeat (10) @(negedge clk);
        wr(3'd0, ctrl_byte(0, 0, 2'b10));
        read16(0, v);
        check(v == 16'h4321, "R10 counter A holds with ADC off", v, 16'h4321);

        // R4 wrong source holds A
        wr(3'd1, mode_byte(0, 1, 0));
        wr(3'd0, ctrl_byte(1, 0, 2'b01));
        repeat (10) @(negedge clk);
        wr(3'd0, ctrl_byte(0, 0, 2'b01));
        read16(0, v);
        check(v == 16'h4321, "R4 counter A holds with other source", v, 16'h4321);

        // R7 blocked access while running
        load16(1, 16'h5555);
        load16(0, 16'h0000);
        wr(3'd1, mode_byte(0, 1, 1));
        wr(3'd0, ctrl_byte(1, 0, 2'b10));
        wr(3'd4, 8'hAA);
        wr(3'd5, 8'hAA);
        rd(3'd3, b);
        check(b == 8'h00, "R7 blocked read A_HI", b, 0);
        rd(3'd5, b);
        check(b == 8'h00, "R7 blocked read B_HI", b, 0);
        wr(3'd0, ctrl_byte(0, 0, 2'b10));
        read16(1, v);
        check(v == 16'h5555, "R7 blocked write ignored", v, 16'h5555);

        // R4/R6 counter A overflow, exact cycle
        load16(0, 16'hFFF0);
        wr(3'd1, mode_byte(0, 1, 0));
        wr(3'd0, ctrl_byte(1, 0, 2'b10));
        repeat (15) @(negedge clk);
        check(irq_flag == 0, "R4 no flag before 16th count", irq_flag, 0);
        @(negedge clk);
        check(irq_flag == 1, "R6 flag on A wrap", irq_flag, 1);
        rd(3'd0, b);
        check(b == ctrl_byte(0, 1, 2'b10), "R6 run cleared", b, ctrl_byte(0, 1, 2'b10));
        read16(0, v);
        check(v == 16'h0000, "R6 counter A stopped at zero", v, 0);
        read16(1, v);
        check(v == 16'h5555, "R5 counter B idle without edges", v, 16'h5555);

        // R8 flag persistence and clearing
        repeat (5) @(negedge clk);
        check(irq_flag == 1, "R8 flag held", irq_flag, 1);
        wr(3'd0, ctrl_byte(0, 1, 2'b10));
        check(irq_flag == 1, "R8 write 1 keeps flag", irq_flag, 1);
        wr(3'd0, ctrl_byte(0, 0, 2'b10));
        check(irq_flag == 0, "R8 write 0 clears flag", irq_flag, 0);

        // R5/R6 counter B overflow, A wraps unselected
        load16(1, 16'hFFFD);
        load16(0, 16'hFFF8);
        wr(3'd1, mode_byte(1, 1, 1));
        wr(3'd0, ctrl_byte(1, 0, 2'b10));
        osc_pulse();
        osc_pulse();
        rd(3'd0, b);
        check(b == ctrl_byte(1, 0, 2'b10), "R6 A wrap does not stop run", b, ctrl_byte(1, 0, 2'b10));
        osc_pulse();
        check(irq_flag == 1, "R6 flag on B wrap", irq_flag, 1);
        read16(1, v);
        check(v == 16'h0000, "R5 counter B counted three edges", v, 0);
        @(negedge clk);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        check(irq_flag == 0, "R8 clear pulse", irq_flag, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule